// File: doc/BRIEF.md
# Link Alignment FIFO with Link-State Machine

This block moves frames from one serial link into the system clock domain and lets the latency of several links be evened out. Frames enter on the link receive clock (`wclk`) with a strobe and a data/idle indication. They are stored in a dual-clock FIFO and leave on the system clock (`rclk`) one word per cycle once reading has started.

A four-state one-hot machine in the link domain decides when writes happen. A resync command sends it to a start state. Idle characters from the link move it to an idle state. Writing starts only with the third data frame after the last idle character. On the system side, a resync arms a delay counter loaded from `rd_delay`, and reads begin when that delay has run out. Software tunes the delay per link until the lowest word count over all links is small. A 16-bit status word shows the FIFO flags, the receiver signal-detect input, the machine state and the read-side word count.

Top module: `link_align_fifo`

## Requirements
- R1: After reset the status word reads 0x4100 (empty flag set, start-state bit set, everything else 0) and `rd_valid` is 0.
- R2: A resync command (one `rclk` cycle on `resync`) forces the link-state machine into its start state from any state. In the start state, bit 8 is the only state bit set in the status word.
- R3: An idle character (`lnk_valid`=1, `lnk_is_data`=0) moves the machine to its idle state (status bit 9) from the start state and from the first-frame state. It does the same from the write state, which stops further writes.
- R4: A data frame received in the start state leaves the machine there. In the idle state a data frame moves it to the first-frame state (bit 10). One more data frame moves it to the write state (bit 11). Neither of these two frames is stored, and every later data frame is stored.
- R5: Stored words leave on `rd_word` in the order they were written, each exactly once, with `rd_valid` high in the cycle each is presented.
- R6: With delay D loaded at the resync, `rd_valid` first rises after the rising `rclk` edge numbered D+2, counting the edge that samples `resync` as edge 0. With D=0 and an empty FIFO, the error flag is still 0 after edge 1 and is 1 after edge 2.
- R7: Status bits 7:0 give the number of stored words once the pointers have crossed over. The empty flag (bit 14) is set when that number is 0. The full flag (bit 15) is set when it is 255. A data frame that arrives in the write state while the FIFO is full is dropped.
- R8: The error flag (bit 13) is set by a write to a full FIFO or by a read attempt on an empty FIFO. It stays set until a resync clears it.
- R9: Status bit 12 follows `rx_sig_det` after crossing into the system clock.
- R10: A resync discards all stored words: the read pointer follows the write pointer until writes are enabled again, so the count returns to 0.
- R11: Between reset and the first resync, no read is made, and stored words stay in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Link receive clock |
| wrst_n | input | 1 | Asynchronous active-low reset, link domain |
| lnk_valid | input | 1 | A character or frame is present this `wclk` cycle |
| lnk_is_data | input | 1 | 1 = data frame, 0 = idle character |
| lnk_word | input | DATA_W | Frame payload |
| rx_sig_det | input | 1 | Optical receiver signal detect, asynchronous |
| rclk | input | 1 | System clock |
| rrst_n | input | 1 | Asynchronous active-low reset, system domain |
| resync | input | 1 | Resync command, one `rclk` cycle |
| rd_delay | input | DLY_W | Read start delay in `rclk` cycles, sampled at resync |
| rd_valid | output | 1 | `rd_word` holds a word read this cycle |
| rd_word | output | DATA_W | Word read from the FIFO |
| status | output | 16 | {full, empty, error, sig_det, write, first, idle, start, count[7:0]} |

## Verification
On every cycle, the assertions check the following: the machine stays one-hot; resync and frame events lead to the right next state; a full write or an empty read leaves its pointer in place; the error flag holds until a resync and clears after one; the read side stays put in its hold and waiting phases. Other behaviour needs the bench's scenarios. These are the exact cycle of the first read for several delays, the order and number of words drained, the fill up to the full mark with one write dropped, the discard on resync, and the state bits and signal-detect bit as they appear across the clock crossing.

// File: rtl/lafifo_pkg.sv
`timescale 1ns/1ps
package lafifo_pkg;

   typedef enum logic [3:0] {
      LS_INIT = 4'b0001,
      LS_IDLE = 4'b0010,
      LS_FRM1 = 4'b0100,
      LS_WREN = 4'b1000
   } link_state_t;

   typedef enum logic [1:0] {
      RP_HOLD = 2'd0,
      RP_WAIT = 2'd1,
      RP_RUN  = 2'd2
   } rd_phase_t;

   localparam int STAT_W      = 16;
   localparam int CNT_FIELD_W = 8;

endpackage

// File: rtl/lafifo_sync.sv
`timescale 1ns/1ps
module lafifo_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   initial assert (STAGES >= 2) else $error("lafifo_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/lafifo_wr_ctrl.sv
`timescale 1ns/1ps
module lafifo_wr_ctrl
   import lafifo_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          rs_tgl_s,
   input  logic          lnk_valid,
   input  logic          lnk_is_data,
   input  logic [DW-1:0] lnk_word,
   input  logic [AW-1:0] rptr_gray_s,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [DW-1:0] mem_wdata,
   output logic [AW-1:0] wptr_gray,
   output logic [3:0]    state_o,
   output logic          wr_err
);

   link_state_t   state, state_nx;
   logic          tgl_q;
   logic          rs_pulse;
   logic [AW-1:0] wptr_bin, wptr_nx, rptr_bin_s, used_w;
   logic          full_w, attempt;

   assign rs_pulse = rs_tgl_s ^ tgl_q;

   always_comb begin
      rptr_bin_s[AW-1] = rptr_gray_s[AW-1];
      for (int i = AW-2; i >= 0; i--) rptr_bin_s[i] = rptr_bin_s[i+1] ^ rptr_gray_s[i];
   end

   assign used_w  = wptr_bin - rptr_bin_s;
   assign full_w  = (used_w == '1);
   assign attempt = lnk_valid && lnk_is_data && (state == LS_WREN) && !rs_pulse;
   assign mem_we  = attempt && !full_w;
   assign wptr_nx = mem_we ? wptr_bin + 1'b1 : wptr_bin;

   always_comb begin
      state_nx = state;
      if (rs_pulse) begin
         state_nx = LS_INIT;
      end else if (lnk_valid) begin
         if (!lnk_is_data) begin
            state_nx = LS_IDLE;
         end else begin
            case (state)
               LS_IDLE: state_nx = LS_FRM1;
               LS_FRM1: state_nx = LS_WREN;
               default: state_nx = state;
            endcase
         end
      end
   end

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         state     <= LS_INIT;
         tgl_q     <= 1'b0;
         wptr_bin  <= '0;
         wptr_gray <= '0;
         wr_err    <= 1'b0;
      end else begin
         state     <= state_nx;
         tgl_q     <= rs_tgl_s;
         wptr_bin  <= wptr_nx;
         wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
         if (rs_pulse)               wr_err <= 1'b0;
         else if (attempt && full_w) wr_err <= 1'b1;
      end
   end

   assign mem_waddr = wptr_bin;
   assign mem_wdata = lnk_word;
   assign state_o   = state;

   // R2: the state register never holds zero or several bits
   a_r2_state_onehot: assert property (@(posedge wclk) disable iff (!wrst_n)
      $onehot(state));

   // R2: a resync seen in the link domain lands in the start state
   a_r2_resync_init: assert property (@(posedge wclk) disable iff (!wrst_n)
      rs_pulse |=> (state == LS_INIT));

   // R3: an idle character always leads to the idle state
   a_r3_idle_char: assert property (@(posedge wclk) disable iff (!wrst_n)
      (lnk_valid && !lnk_is_data && !rs_pulse) |=> (state == LS_IDLE));

   // R4: a second data frame after the idle state enables writing
   a_r4_frm1_to_wren: assert property (@(posedge wclk) disable iff (!wrst_n)
      (state == LS_FRM1 && lnk_valid && lnk_is_data && !rs_pulse) |=> (state == LS_WREN));

   // R7: a frame offered to a full FIFO does not move the write pointer
   a_r7_full_no_advance: assert property (@(posedge wclk) disable iff (!wrst_n)
      (attempt && full_w) |=> $stable(wptr_bin));

endmodule

// File: rtl/lafifo_rd_ctrl.sv
`timescale 1ns/1ps
module lafifo_rd_ctrl
   import lafifo_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DLY_W = 8
) (
   input  logic             rclk,
   input  logic             rrst_n,
   input  logic             resync,
   input  logic [DLY_W-1:0] rd_delay,
   input  logic [AW-1:0]    wptr_gray_s,
   input  logic             wren_s,
   output logic             rd_fire,
   output logic [AW-1:0]    rd_addr,
   output logic [AW-1:0]    rptr_gray,
   output logic [AW-1:0]    used_r,
   output logic             empty_r,
   output logic             full_r,
   output logic             rd_err
);

   rd_phase_t        phase;
   logic [DLY_W-1:0] dly_cnt;
   logic [AW-1:0]    rptr_bin, rptr_nx, wptr_bin_s;
   logic             chase;

   always_comb begin
      wptr_bin_s[AW-1] = wptr_gray_s[AW-1];
      for (int i = AW-2; i >= 0; i--) wptr_bin_s[i] = wptr_bin_s[i+1] ^ wptr_gray_s[i];
   end

   assign used_r  = wptr_bin_s - rptr_bin;
   assign empty_r = (used_r == '0);
   assign full_r  = (used_r == '1);
   assign rd_fire = (phase == RP_RUN) && !empty_r && !resync;
   assign chase   = (phase != RP_RUN) && !wren_s;

   always_comb begin
      if (rd_fire)    rptr_nx = rptr_bin + 1'b1;
      else if (chase) rptr_nx = wptr_bin_s;
      else            rptr_nx = rptr_bin;
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         phase     <= RP_HOLD;
         dly_cnt   <= '0;
         rd_err    <= 1'b0;
         rptr_bin  <= '0;
         rptr_gray <= '0;
      end else begin
         rptr_bin  <= rptr_nx;
         rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
         if (resync) begin
            phase   <= RP_WAIT;
            dly_cnt <= rd_delay;
            rd_err  <= 1'b0;
         end else begin
            case (phase)
               RP_WAIT: begin
                  if (dly_cnt == '0) phase <= RP_RUN;
                  else               dly_cnt <= dly_cnt - 1'b1;
               end
               RP_RUN:  if (empty_r) rd_err <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign rd_addr = rptr_bin;

   // R6: while the delay is still running the read side keeps waiting
   a_r6_wait_holds: assert property (@(posedge rclk) disable iff (!rrst_n)
      (phase == RP_WAIT && dly_cnt != '0 && !resync) |=> (phase == RP_WAIT));

   // R11: without a resync the read side never leaves its hold phase
   a_r11_hold_stays: assert property (@(posedge rclk) disable iff (!rrst_n)
      (phase == RP_HOLD && !resync) |=> (phase == RP_HOLD));

   // R8: error flag is sticky until resync
   a_r8_err_sticky: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rd_err && !resync) |=> rd_err);

   // R8: a resync clears the read-side error
   a_r8_err_clear: assert property (@(posedge rclk) disable iff (!rrst_n)
      resync |=> !rd_err);

   // R5: a read attempt on an empty FIFO does not move the read pointer
   a_r5_empty_no_advance: assert property (@(posedge rclk) disable iff (!rrst_n)
      (phase == RP_RUN && empty_r && !resync) |=> $stable(rptr_bin));

endmodule

// File: rtl/link_align_fifo.sv
`timescale 1ns/1ps
module link_align_fifo
   import lafifo_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 8,
   parameter int DLY_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              lnk_valid,
   input  logic              lnk_is_data,
   input  logic [DATA_W-1:0] lnk_word,
   input  logic              rx_sig_det,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              resync,
   input  logic [DLY_W-1:0]  rd_delay,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_word,
   output logic [15:0]       status
);

   localparam int DEPTH = 1 << ADDR_W;

   initial assert (ADDR_W >= 2 && ADDR_W <= CNT_FIELD_W)
      else $error("link_align_fifo: ADDR_W must lie in 2..8");
   initial assert (DATA_W >= 1 && DLY_W >= 1)
      else $error("link_align_fifo: DATA_W and DLY_W must be positive");

   logic [DATA_W-1:0]      mem [DEPTH];
   logic                   mem_we;
   logic [ADDR_W-1:0]      mem_waddr;
   logic [DATA_W-1:0]      mem_wdata;
   logic [ADDR_W-1:0]      wptr_gray, rptr_gray, wptr_gray_s, rptr_gray_s;
   logic [3:0]             state_w;
   logic                   wr_err;
   logic                   rs_tgl, rs_tgl_s;
   logic [4:0]             wside_s;
   logic                   sig_det_s;
   logic                   rd_fire, empty_r, full_r, rd_err;
   logic [ADDR_W-1:0]      rd_addr, used_r;
   logic [CNT_FIELD_W-1:0] cnt_field;

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) rs_tgl <= 1'b0;
      else         rs_tgl <= rs_tgl ^ resync;
   end

   lafifo_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rs_sync (
      .clk(wclk), .rst_n(wrst_n), .d(rs_tgl), .q(rs_tgl_s));

   lafifo_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_rptr_sync (
      .clk(wclk), .rst_n(wrst_n), .d(rptr_gray), .q(rptr_gray_s));

   lafifo_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_wptr_sync (
      .clk(rclk), .rst_n(rrst_n), .d(wptr_gray), .q(wptr_gray_s));

   lafifo_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00001)) u_wside_sync (
      .clk(rclk), .rst_n(rrst_n), .d({wr_err, state_w}), .q(wside_s));

   lafifo_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sd_sync (
      .clk(rclk), .rst_n(rrst_n), .d(rx_sig_det), .q(sig_det_s));

   lafifo_wr_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_wr (
      .wclk(wclk), .wrst_n(wrst_n), .rs_tgl_s(rs_tgl_s),
      .lnk_valid(lnk_valid), .lnk_is_data(lnk_is_data), .lnk_word(lnk_word),
      .rptr_gray_s(rptr_gray_s), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .wptr_gray(wptr_gray), .state_o(state_w),
      .wr_err(wr_err));

   lafifo_rd_ctrl #(.AW(ADDR_W), .DLY_W(DLY_W)) u_rd (
      .rclk(rclk), .rrst_n(rrst_n), .resync(resync), .rd_delay(rd_delay),
      .wptr_gray_s(wptr_gray_s), .wren_s(wside_s[3]), .rd_fire(rd_fire),
      .rd_addr(rd_addr), .rptr_gray(rptr_gray), .used_r(used_r),
      .empty_r(empty_r), .full_r(full_r), .rd_err(rd_err));

   always_ff @(posedge wclk) begin
      if (mem_we) mem[mem_waddr] <= mem_wdata;
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rd_valid <= 1'b0;
         rd_word  <= '0;
      end else begin
         rd_valid <= rd_fire;
         if (rd_fire) rd_word <= mem[rd_addr];
      end
   end

   generate
      if (ADDR_W == CNT_FIELD_W) begin : g_cnt_full
         assign cnt_field = used_r;
      end else begin : g_cnt_pad
         assign cnt_field = {{(CNT_FIELD_W-ADDR_W){1'b0}}, used_r};
      end
   endgenerate

   assign status = {full_r, empty_r, rd_err | wside_s[4], sig_det_s, wside_s[3:0], cnt_field};

   // R7: the two count flags never both show
   a_r7_flags_exclusive: assert property (@(posedge rclk) disable iff (!rrst_n)
      !(status[15] && status[14]));

   // R5: a word presented on the output was taken while words were held
   a_r5_valid_from_fire: assert property (@(posedge rclk) disable iff (!rrst_n)
      rd_fire |=> rd_valid);

endmodule

// File: tb/link_align_fifo_test.sv
`timescale 1ns/1ps
module link_align_fifo_test;

   logic        wclk = 1'b0, rclk = 1'b0;
   logic        wrst_n = 1'b0, rrst_n = 1'b0;
   logic        lnk_valid = 1'b0, lnk_is_data = 1'b0;
   logic [15:0] lnk_word = '0;
   logic        rx_sig_det = 1'b0;
   logic        resync = 1'b0;
   logic [7:0]  rd_delay = '0;
   logic        rd_valid;
   logic [15:0] rd_word;
   logic [15:0] status;

   int total = 0;
   int bad   = 0;

   always #2 rclk = ~rclk;
   always #3 wclk = ~wclk;

   link_align_fifo #(.DATA_W(16), .ADDR_W(8), .DLY_W(8), .SYNC_STAGES(2)) uut (
      .wclk(wclk), .wrst_n(wrst_n), .lnk_valid(lnk_valid), .lnk_is_data(lnk_is_data),
      .lnk_word(lnk_word), .rx_sig_det(rx_sig_det), .rclk(rclk), .rrst_n(rrst_n),
      .resync(resync), .rd_delay(rd_delay), .rd_valid(rd_valid), .rd_word(rd_word),
      .status(status));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] expw(input int sc, input int i);
      return 16'(sc * 4096 + i * 37 + 5);
   endfunction

   task automatic frame(input bit d, input logic [15:0] w);
      @(negedge wclk);
      lnk_valid = 1'b1; lnk_is_data = d; lnk_word = w;
   endtask

   task automatic quiet(input int n);
      @(negedge wclk);
      lnk_valid = 1'b0;
      repeat (n) @(posedge wclk);
   endtask

   task automatic chk_state(input logic [3:0] exp, input string req);
      @(negedge rclk);
      chk(status[11:8] == exp, req, int'(status[11:8]), int'(exp));
   endtask

   // Link-side stimulus for one scenario, starting right after the resync
   task automatic feed(input int sc, input int n);
      repeat (16) @(negedge rclk);
      chk(status[11:8] == 4'b0001, "R2 start state after resync", int'(status[11:8]), 1);
      chk(status[7:0] == 8'd0, "R10 count cleared by resync", int'(status[7:0]), 0);
      chk(status[14] == 1'b1, "R10 empty after resync", int'(status[14]), 1);
      chk(status[13] == 1'b0, "R8 error cleared by resync", int'(status[13]), 0);
      quiet(10);
      if (sc == 0) begin
         frame(1'b1, 16'hDEAD); quiet(4);
         chk_state(4'b0001, "R4 data in start state ignored");
      end
      frame(1'b0, '0); quiet(4);
      chk_state(4'b0010, "R3 idle char to idle state");
      if (sc == 1) begin
         frame(1'b1, 16'hBEEF); quiet(4);
         chk_state(4'b0100, "R4 first data frame");
         frame(1'b0, '0); quiet(4);
         chk_state(4'b0010, "R3 idle from first-frame state");
      end
      frame(1'b1, expw(sc, 1)); quiet(4);
      chk_state(4'b0100, "R4 first data frame");
      frame(1'b1, expw(sc, 2)); quiet(4);
      chk_state(4'b1000, "R4 second data frame enables writes");
      chk(status[7:0] == 8'd0, "R4 first two frames not stored", int'(status[7:0]), 0);
      for (int i = 3; i <= n; i++) frame(1'b1, expw(sc, i));
      quiet(6);
      @(negedge rclk);
      chk(int'(status[7:0]) == n - 2, "R7 count of stored words", int'(status[7:0]), n - 2);
      chk(status[14] == 1'b0, "R7 not empty", int'(status[14]), 0);
   endtask

   // System-side: resync, time the first read, drain and check the words
   task automatic drain(input int sc, input int dly, input int n);
      int  k;
      int  got;
      bit  found;
      rd_delay = 8'(dly);
      @(negedge rclk); resync = 1'b1;
      @(negedge rclk); resync = 1'b0;
      k = 0; found = 1'b0;
      while (!found && k < 400) begin
         @(posedge rclk); k++;
         @(negedge rclk);
         if (rd_valid) found = 1'b1;
      end
      chk(k == dly + 2, "R6 first read cycle", k, dly + 2);
      got = 0;
      while (rd_valid && got < 300) begin
         chk(rd_word == expw(sc, got + 3), "R5 word order", int'(rd_word), int'(expw(sc, got + 3)));
         got++;
         @(negedge rclk);
      end
      chk(got == n - 2, "R5 number of words drained", got, n - 2);
      chk(status[13] == 1'b1, "R8 read from empty sets error", int'(status[13]), 1);
      repeat (10) @(negedge rclk);
      chk(status[13] == 1'b1, "R8 error stays set", int'(status[13]), 1);
      chk(status[14] == 1'b1, "R7 empty after drain", int'(status[14]), 1);
   endtask

   initial begin : watchdog
      #400000;
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int dlys [6];
      int ns   [6];
      dlys = '{150, 200, 100, 120, 255, 0};
      ns   = '{5, 8, 3, 12, 16, 0};

      repeat (5) @(negedge rclk);
      wrst_n = 1'b1; rrst_n = 1'b1;
      @(negedge rclk);
      chk(status == 16'h4100, "R1 reset status word", int'(status), 16'h4100);
      chk(rd_valid == 1'b0, "R1 no output after reset", int'(rd_valid), 0);

      rx_sig_det = 1'b1;
      repeat (4) @(negedge rclk);
      chk(status[12] == 1'b1, "R9 signal detect high", int'(status[12]), 1);
      rx_sig_det = 1'b0;
      repeat (4) @(negedge rclk);
      chk(status[12] == 1'b0, "R9 signal detect low", int'(status[12]), 0);

      // Fill to the full mark before any resync: the read side holds
      frame(1'b0, '0);
      frame(1'b1, 16'h0001);
      frame(1'b1, 16'h0002);
      for (int i = 0; i < 254; i++) frame(1'b1, expw(9, i));
      quiet(6);
      @(negedge rclk);
      chk(status[7:0] == 8'd254, "R11 words held before first resync", int'(status[7:0]), 254);
      chk(status[15] == 1'b0, "R7 not full at 254", int'(status[15]), 0);
      chk(status[13] == 1'b0, "R8 no error yet", int'(status[13]), 0);
      frame(1'b1, expw(9, 254)); quiet(6);
      @(negedge rclk);
      chk(status[7:0] == 8'd255, "R7 count reaches 255", int'(status[7:0]), 255);
      chk(status[15] == 1'b1, "R7 full flag at 255", int'(status[15]), 1);
      chk(status[13] == 1'b0, "R8 full alone is no error", int'(status[13]), 0);
      frame(1'b1, expw(9, 255)); quiet(6);
      repeat (2) @(negedge rclk);
      chk(status[13] == 1'b1, "R8 write to full sets error", int'(status[13]), 1);
      chk(status[7:0] == 8'd255, "R7 write to full dropped", int'(status[7:0]), 255);
      repeat (20) @(negedge rclk);
      chk(status[13] == 1'b1, "R8 error sticky without resync", int'(status[13]), 1);
      chk(rd_valid == 1'b0, "R11 no read before first resync", int'(rd_valid), 0);

      for (int sc = 0; sc < 5; sc++) begin
         fork
            drain(sc, dlys[sc], ns[sc]);
            feed(sc, ns[sc]);
         join
      end

      // Zero delay with nothing stored: immediate read attempt on empty
      rd_delay = 8'd0;
      @(negedge rclk); resync = 1'b1;
      @(negedge rclk); resync = 1'b0;
      @(posedge rclk); @(negedge rclk);
      chk(status[13] == 1'b0, "R6 zero delay edge 1 no error", int'(status[13]), 0);
      @(posedge rclk); @(negedge rclk);
      chk(status[13] == 1'b1, "R6 zero delay edge 2 underflow", int'(status[13]), 1);
      chk(rd_valid == 1'b0, "R6 zero delay nothing read", int'(rd_valid), 0);
      repeat (16) @(negedge rclk);
      chk(status[11:8] == 4'b0001, "R2 start state from write state", int'(status[11:8]), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule